// File: doc/BRIEF.md
# Output Compare Bank

This block is a bank of eight output-compare channels built on one 16-bit up-counter. The counter advances on a prescaled tick whose rate is chosen by a 3-bit divider code. It can run free, or it can be sent back to zero when the master channel (channel 7) matches. On the tick where the counter equals a channel's compare value, that channel raises its flag and applies its programmed action to its output pin. The master channel can also impose a data pattern on any subset of the pins, and it overrides the other channels when both act in the same cycle.

A control plane drives the configuration inputs directly. Through them it can write compare values, pulse force strobes that trigger a channel action at once, and clear flags with write-one-to-clear pulses. Typical uses are generating several PWM outputs that share one period set by channel 7, placing single edges at chosen times, and toggling pins on counter wrap.

Top module: `ocmp_bank`

## Requirements
- R1: While `cntEn` is 1 the counter advances once every 2^`preSel` enabled clock cycles, starting from a cleared prescaler. While `cntEn` is 0 the counter and the prescaler hold their values.
- R2: A tick that takes the counter from FFFF to 0000 sets `ovfFlag`. A one-cycle pulse on `ovfClr` clears it. `ovfIrq` equals `ovfFlag` AND `ovfIntEn`.
- R3: When `resetOnMatch` is 1, a channel-7 match returns the counter to 0000 on that tick. When it is 0 the counter runs free.
- R4: Each channel's 2-bit action in `pinAct[2i+1:2i]` is applied to `pins[i]` on its match: 00 no change, 01 toggle, 10 drive 0, 11 drive 1. Pins change only on a channel event or an overflow toggle.
- R5: A match sets `chFlag[i]`. A pulse on `flagClr[i]` clears it. `chIrq[i]` equals `chFlag[i]` AND `intEn[i]`.
- R6: On a channel-7 event, every pin whose `ovMask` bit is 1 takes its `ovData` bit. This wins over any other action on that pin in the same cycle.
- R7: A pulse on `forceStb[i]` applies channel i's action on the next edge without setting its flag. Forcing channel 7 also applies the mask/data override.
- R8: `togOvf[i]` toggles `pins[i]` on counter overflow only when `ocSel[i]` is 1.
- R9: Reset clears the counter, the prescaler, the compare registers, all flags and all pins.
- R10: When `fastClr` is 1, writing channel i's compare register clears `chFlag[i]`. When `fastClr` is 0, that write leaves the flag set.
- R11: A match acts once per counter value, on the tick where the counter equals the compare value. Cycles spent at that count between ticks cause no further action.
- R12: A channel with `ocSel[i]` = 0 never matches, never sets its flag and never drives its pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Counter and prescaler enable |
| preSel | input | 3 | Prescaler code, divide by 2^preSel |
| resetOnMatch | input | 1 | Return counter to zero on channel-7 match |
| fastClr | input | 1 | Compare-register write also clears that channel's flag |
| ocSel | input | 8 | Per-channel output-compare enable |
| pinAct | input | 16 | Per-channel 2-bit pin action |
| togOvf | input | 8 | Per-channel toggle on counter overflow |
| ovMask | input | 8 | Pins overridden by channel 7 |
| ovData | input | 8 | Values written by the channel-7 override |
| cmpWrEn | input | 8 | Compare-register write enables |
| cmpWrData | input | 16 | Compare-register write data |
| forceStb | input | 8 | Force-compare strobes |
| flagClr | input | 8 | Channel flag clear pulses |
| ovfClr | input | 1 | Overflow flag clear pulse |
| intEn | input | 8 | Channel interrupt enables |
| ovfIntEn | input | 1 | Overflow interrupt enable |
| count | output | 16 | Counter value |
| chFlag | output | 8 | Channel match flags |
| ovfFlag | output | 1 | Counter overflow flag |
| chIrq | output | 8 | Channel interrupt requests |
| ovfIrq | output | 1 | Overflow interrupt request |
| pins | output | 8 | Compare output pins |

## Verification
The hardest case to reach is the counter wrap, because it needs a full 65536 ticks. The stimulus runs the counter at divide-by-1 until it reads FFFF and confirms that nothing has fired yet. One more tick must then set the overflow flag and toggle only the pin whose channel is enabled for output compare. A second hard case is two actions landing on the same pin in the same cycle. It is produced by giving channel 0 and channel 7 equal compare values with opposing results, so that only a design that gives the override priority shows the masked data bit.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int OC_CH    = 8;
  localparam int OC_W     = 16;
  localparam int OC_PRE_W = 3;
  localparam int MST_CH   = OC_CH - 1;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pinAct_e;

  // Strobes from control to the pin datapath, valid for one cycle.
  typedef struct packed {
    logic [OC_CH-1:0] chEvt;  // channel match or force
    logic             mstEvt; // master channel event
    logic             ovfEvt; // counter wrap
  } ocStrobe_t;
endpackage

// File: rtl/ocmp_timebase.sv
module ocmp_timebase #(
  parameter int CNT_W = ocmp_pkg::OC_W,
  parameter int PRE_W = ocmp_pkg::OC_PRE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic [PRE_W-1:0] preSel,
  input  logic             clrReq,
  output logic             tick,
  output logic             wrapEvt,
  output logic [CNT_W-1:0] count
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] divMask;

  always_comb begin
    for (int b = 0; b < DIV_W; b++) divMask[b] = (b < int'(preSel));
  end

  assign tick    = cntEn && ((preCnt & divMask) == divMask);
  assign wrapEvt = tick && (count == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
    end else begin
      if (cntEn) preCnt <= preCnt + 1'b1;
      if (tick) count <= clrReq ? '0 : count + 1'b1;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(count)); // R1
  AST_DIV1_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && preSel == '0 && !clrReq && count != '1) |=> count == $past(count) + 1'b1); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> count == '0); // R2
  AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (tick && clrReq) |=> count == '0); // R3
endmodule

// File: rtl/ocmp_ctrl.sv
module ocmp_ctrl
  import ocmp_pkg::*;
#(
  parameter int CNT_W = OC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrapEvt,
  input  logic [CNT_W-1:0] count,
  input  logic             resetOnMatch,
  input  logic             fastClr,
  input  logic [OC_CH-1:0] ocSel,
  input  logic [OC_CH-1:0] cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic [OC_CH-1:0] forceStb,
  input  logic [OC_CH-1:0] flagClr,
  input  logic             ovfClr,
  output logic             clrReq,
  output logic [OC_CH-1:0] chFlag,
  output logic             ovfFlag,
  output ocStrobe_t        stb
);
  logic [CNT_W-1:0] cmpReg [OC_CH];
  logic [OC_CH-1:0] hit;

  for (genvar g = 0; g < OC_CH; g++) begin : gCh
    assign hit[g] = tick && ocSel[g] && (cmpReg[g] == count);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpReg[g] <= '0;
        chFlag[g] <= 1'b0;
      end else begin
        if (cmpWrEn[g]) cmpReg[g] <= cmpWrData;
        if (hit[g]) chFlag[g] <= 1'b1;
        else if (flagClr[g] || (fastClr && cmpWrEn[g])) chFlag[g] <= 1'b0;
      end
    end

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (tick && ocSel[g] && count == cmpReg[g]) |=> chFlag[g]); // R5
    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (forceStb[g] && !hit[g] && !chFlag[g]) |=> !chFlag[g]); // R7
    AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (fastClr && cmpWrEn[g] && !hit[g]) |=> !chFlag[g]); // R10
    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (!ocSel[g] && !chFlag[g]) |=> !chFlag[g]); // R12
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (wrapEvt) ovfFlag <= 1'b1;
    else if (ovfClr) ovfFlag <= 1'b0;
  end

  assign clrReq     = resetOnMatch && hit[MST_CH];
  assign stb.chEvt  = hit | (forceStb & ocSel);
  assign stb.mstEvt = hit[MST_CH] | (forceStb[MST_CH] & ocSel[MST_CH]);
  assign stb.ovfEvt = wrapEvt;

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> ovfFlag); // R2
endmodule

// File: rtl/ocmp_pinpath.sv
module ocmp_pinpath
  import ocmp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ocStrobe_t          stb,
  input  logic [OC_CH-1:0]   ocSel,
  input  logic [2*OC_CH-1:0] pinAct,
  input  logic [OC_CH-1:0]   togOvf,
  input  logic [OC_CH-1:0]   ovMask,
  input  logic [OC_CH-1:0]   ovData,
  output logic [OC_CH-1:0]   pins
);
  logic [OC_CH-1:0] pinsNxt;

  // Order of resolution: overflow toggle, channel action, master override.
  always_comb begin
    pinsNxt = pins;
    for (int i = 0; i < OC_CH; i++) begin
      if (stb.ovfEvt && togOvf[i] && ocSel[i]) pinsNxt[i] = ~pinsNxt[i];
      if (stb.chEvt[i]) begin
        case (pinAct_e'(pinAct[2*i +: 2]))
          ACT_TOGGLE: pinsNxt[i] = ~pinsNxt[i];
          ACT_LOW:    pinsNxt[i] = 1'b0;
          ACT_HIGH:   pinsNxt[i] = 1'b1;
          default:    ;
        endcase
      end
      if (stb.mstEvt && ovMask[i]) pinsNxt[i] = ovData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pins <= '0;
    else pins <= pinsNxt;
  end

  for (genvar g = 0; g < OC_CH; g++) begin : gChk
    AST_MASTER_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (stb.mstEvt && ovMask[g]) |=> pins[g] == $past(ovData[g])); // R6
  end

  AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!(|stb.chEvt) && !stb.ovfEvt) |=> $stable(pins)); // R4
endmodule

// File: rtl/ocmp_bank.sv
module ocmp_bank
  import ocmp_pkg::*;
#(
  parameter int CNT_W = OC_W,
  parameter int PRE_W = OC_PRE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntEn,
  input  logic [PRE_W-1:0]   preSel,
  input  logic               resetOnMatch,
  input  logic               fastClr,
  input  logic [OC_CH-1:0]   ocSel,
  input  logic [2*OC_CH-1:0] pinAct,
  input  logic [OC_CH-1:0]   togOvf,
  input  logic [OC_CH-1:0]   ovMask,
  input  logic [OC_CH-1:0]   ovData,
  input  logic [OC_CH-1:0]   cmpWrEn,
  input  logic [CNT_W-1:0]   cmpWrData,
  input  logic [OC_CH-1:0]   forceStb,
  input  logic [OC_CH-1:0]   flagClr,
  input  logic               ovfClr,
  input  logic [OC_CH-1:0]   intEn,
  input  logic               ovfIntEn,
  output logic [CNT_W-1:0]   count,
  output logic [OC_CH-1:0]   chFlag,
  output logic               ovfFlag,
  output logic [OC_CH-1:0]   chIrq,
  output logic               ovfIrq,
  output logic [OC_CH-1:0]   pins
);
  logic      tick;
  logic      wrapEvt;
  logic      clrReq;
  ocStrobe_t stb;

  ocmp_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timebase (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .preSel(preSel), .clrReq(clrReq),
    .tick(tick), .wrapEvt(wrapEvt), .count(count)
  );

  ocmp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrapEvt(wrapEvt), .count(count),
    .resetOnMatch(resetOnMatch), .fastClr(fastClr), .ocSel(ocSel),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .forceStb(forceStb),
    .flagClr(flagClr), .ovfClr(ovfClr), .clrReq(clrReq), .chFlag(chFlag),
    .ovfFlag(ovfFlag), .stb(stb)
  );

  ocmp_pinpath u_pinpath (
    .clk(clk), .rstN(rstN), .stb(stb), .ocSel(ocSel), .pinAct(pinAct),
    .togOvf(togOvf), .ovMask(ovMask), .ovData(ovData), .pins(pins)
  );

  assign chIrq  = chFlag & intEn;
  assign ovfIrq = ovfFlag & ovfIntEn;
endmodule

// File: tb/ocmp_bank_bench.sv
`timescale 1ns/1ps
module ocmp_bank_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cntEn;
  logic [2:0]  preSel;
  logic        resetOnMatch;
  logic        fastClr;
  logic [7:0]  ocSel;
  logic [15:0] pinAct;
  logic [7:0]  togOvf;
  logic [7:0]  ovMask;
  logic [7:0]  ovData;
  logic [7:0]  cmpWrEn;
  logic [15:0] cmpWrData;
  logic [7:0]  forceStb;
  logic [7:0]  flagClr;
  logic        ovfClr;
  logic [7:0]  intEn;
  logic        ovfIntEn;
  logic [15:0] count;
  logic [7:0]  chFlag;
  logic        ovfFlag;
  logic [7:0]  chIrq;
  logic        ovfIrq;
  logic [7:0]  pins;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ocmp_bank u_ocmp_bank (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .preSel(preSel),
    .resetOnMatch(resetOnMatch), .fastClr(fastClr), .ocSel(ocSel),
    .pinAct(pinAct), .togOvf(togOvf), .ovMask(ovMask), .ovData(ovData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .forceStb(forceStb),
    .flagClr(flagClr), .ovfClr(ovfClr), .intEn(intEn), .ovfIntEn(ovfIntEn),
    .count(count), .chFlag(chFlag), .ovfFlag(ovfFlag), .chIrq(chIrq),
    .ovfIrq(ovfIrq), .pins(pins)
  );

  // Prescaler table: code, enabled cycles, expected count (cycles >> code).
  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] cyc;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd0, 16'd37,  16'd37},
    '{3'd1, 16'd37,  16'd18},
    '{3'd2, 16'd40,  16'd10},
    '{3'd3, 16'd41,  16'd5},
    '{3'd4, 16'd15,  16'd0},
    '{3'd5, 16'd100, 16'd3},
    '{3'd7, 16'd127, 16'd0},
    '{3'd7, 16'd128, 16'd1},
    '{3'd7, 16'd300, 16'd2}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; cntEn = 1'b0; preSel = '0; resetOnMatch = 1'b0; fastClr = 1'b0;
    ocSel = '0; pinAct = '0; togOvf = '0; ovMask = '0; ovData = '0;
    cmpWrEn = '0; cmpWrData = '0; forceStb = '0; flagClr = '0; ovfClr = 1'b0;
    intEn = '0; ovfIntEn = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic cmpWrite(input logic [7:0] mask, input logic [15:0] val);
    cmpWrEn = mask; cmpWrData = val;
    step(1);
    cmpWrEn = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // Table walk: R1 divide ratios and hold while disabled
    for (int v = 0; v < 9; v++) begin
      doReset();
      preSel = VECS[v].sel;
      cntEn = 1'b1;
      step(int'(VECS[v].cyc));
      cntEn = 1'b0;
      chk("R1 prescaled count", 32'(count), 32'(VECS[v].exp));
      step(5);
      chk("R1 hold when disabled", 32'(count), 32'(VECS[v].exp));
    end

    // R9: reset state, compare registers cleared
    doReset();
    chk("R9 count", 32'(count), 32'h0);
    chk("R9 flags", 32'({chFlag, ovfFlag}), 32'h0);
    chk("R9 pins/irq", 32'({pins, chIrq, ovfIrq}), 32'h0);
    ocSel = 8'h01; pinAct = 16'h0003; cntEn = 1'b1;
    step(1);
    cntEn = 1'b0;
    chk("R9 compare reg cleared (match at 0)", 32'(pins), 32'h01);

    // R4/R5/R7/R12: actions, flags, force, unselected channel
    doReset();
    chk("R9 pins cleared after use", 32'(pins), 32'h0);
    ocSel = 8'h07; pinAct = 16'h00F7;
    cmpWrite(8'h0F, 16'd5);
    forceStb = 8'h04;
    step(1);
    forceStb = '0;
    chk("R7 force drives pin", 32'(pins), 32'h04);
    chk("R7 force sets no flag", 32'(chFlag), 32'h0);
    pinAct = 16'h00E7; intEn = 8'h01; cntEn = 1'b1;
    step(5);
    chk("R4 before match", 32'(pins), 32'h04);
    step(1);
    cntEn = 1'b0;
    chk("R1 count", 32'(count), 32'd6);
    chk("R4 high/toggle/low, R12 unselected", 32'(pins), 32'h03);
    chk("R5 flags, R12 no flag", 32'(chFlag), 32'h07);
    chk("R5 irq", 32'(chIrq), 32'h01);
    flagClr = 8'h01;
    step(1);
    flagClr = '0;
    chk("R5 clear", 32'({chFlag, chIrq}), 32'h0600);
    fastClr = 1'b1;
    cmpWrite(8'h02, 16'd100);
    chk("R10 fast clear", 32'(chFlag), 32'h04);
    fastClr = 1'b0;
    cmpWrite(8'h04, 16'd100);
    chk("R10 no clear without fast", 32'(chFlag), 32'h04);

    // R11: divide by 4, toggle acts once while count sits at match value
    doReset();
    preSel = 3'd2; ocSel = 8'h01; pinAct = 16'h0001;
    cmpWrite(8'h01, 16'd3);
    cntEn = 1'b1;
    step(20);
    cntEn = 1'b0;
    chk("R11 count", 32'(count), 32'd5);
    chk("R11 single toggle", 32'(pins), 32'h01);

    // R6: master override beats channel 0 in the same cycle
    doReset();
    ocSel = 8'h81; pinAct = 16'h0003; ovMask = 8'h03; ovData = 8'h02;
    cmpWrite(8'h81, 16'd4);
    cntEn = 1'b1;
    step(5);
    cntEn = 1'b0;
    chk("R6 override wins", 32'(pins), 32'h02);
    chk("R5 both flags", 32'(chFlag), 32'h81);
    flagClr = 8'hFF;
    step(1);
    flagClr = '0;
    ovData = 8'h01; forceStb = 8'h80;
    step(1);
    forceStb = '0;
    chk("R7 force master override", 32'(pins), 32'h01);
    chk("R7 force master no flag", 32'(chFlag), 32'h0);

    // R3: reset on channel-7 match
    doReset();
    ocSel = 8'h80; pinAct = 16'h4000; resetOnMatch = 1'b1;
    cmpWrite(8'h80, 16'd9);
    cntEn = 1'b1;
    step(10);
    chk("R3 count back to zero", 32'(count), 32'h0);
    chk("R3 toggle at match", 32'(pins), 32'h80);
    step(10);
    cntEn = 1'b0;
    chk("R3 second period", 32'({count, pins}), 32'h0);

    // R2/R8: overflow flag, interrupt, toggle on overflow
    doReset();
    ocSel = 8'h01; togOvf = 8'h03; ovfIntEn = 1'b1; cntEn = 1'b1;
    step(65535);
    chk("R2 count at max", 32'(count), 32'hFFFF);
    chk("R2 no flag before wrap", 32'({ovfFlag, pins}), 32'h0);
    step(1);
    cntEn = 1'b0;
    chk("R2 wrap to zero", 32'(count), 32'h0);
    chk("R2 flag and irq", 32'({ovfFlag, ovfIrq}), 32'h3);
    chk("R8 toggle only selected", 32'(pins), 32'h01);
    ovfClr = 1'b1;
    step(1);
    ovfClr = 1'b0;
    chk("R2 clear", 32'({ovfFlag, ovfIrq}), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule